// File: doc/BRIEF.md
# SPI Clock Divider and Inactivity Timer

This block is a reloadable down-counter that serves an SPI port in three roles. The role is picked by a small control register. With the port switched on in master mode, each expiry of the counter flips the serial clock output, so the port gets a clock of any even division of the system clock. With the port switched on in slave mode, the counter instead watches the incoming serial clock. Every edge restarts the count, and an expiry raises a sticky abort flag. With the port switched off, the same counter can run as a plain periodic timer that pulses an interrupt line.

Software reaches the block through a byte-wide register port with four addresses: reload low byte, reload high byte, control and status. A 16-bit word read path is also provided. While the port is on, one control bit chooses whether the two reload addresses read back the programmed reload value or the live count. While the port is off, the same bit switches the timer on and off. So that two separate byte reads of a running count stay consistent, reading the high byte captures the matching low byte. The SPI data shifter is not part of this block.

Top module: `sck_rate_gen`

## Requirements
- R1: After synchronous reset, the reload value and control register are zero, `sck_o` is 0, `tmr_irq` is 0, `abort` is 0 and `rd_word` reads 0.
- R2: With control field port=00 (bits 1:0) and dual bit (bit 2) = 1, the counter runs as a timer. `tmr_irq` pulses once every N system clocks for reload N. The first pulse is seen N-1 cycles after the edge that writes the control register.
- R3: A reload value of 0 acts as 65536: the first timer pulse comes 65535 cycles after enabling.
- R4: With port=00 and dual bit 0 the timer is off and `tmr_irq` never asserts; `tmr_irq` also stays 0 whenever port is non-zero.
- R5: With port non-zero and master bit (bit 3) = 1, every counter expiry toggles `sck_o`, giving a serial clock period of 2N system clocks.
- R6: Whenever the block is not generating the clock, `sck_o` rests at the idle level given by control bit 4.
- R7: In slave mode (port non-zero, master bit 0), every change of `sck_in` restarts the count from the reload value, so `abort` stays 0 while edges arrive within N cycles.
- R8: In slave mode, an expiry without an edge in the same cycle sets `abort`. The flag stays set until status address 3 is written with bit 0 = 1; writing 0 leaves it set.
- R9: Addresses 0 (low) and 1 (high) and `rd_word` return the live count when port is non-zero and dual bit = 1; otherwise they return the reload value.
- R10: `rd_word` gives both halves of the selected value from the same cycle, so it tracks the live count down by one per cycle.
- R11: In live view, a read of address 1 captures the low byte of the same count, and a later read of address 0 returns that captured byte rather than the current low byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the byte capture) |
| addr | input | 2 | Register address: 0 low, 1 high, 2 control, 3 status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| rd_word | output | 16 | Word view of reload value or live count |
| sck_in | input | 1 | Serial clock from the bus (slave role) |
| sck_o | output | 1 | Generated serial clock (master role) |
| tmr_irq | output | 1 | One-cycle periodic timer pulse |
| abort | output | 1 | Sticky slave inactivity flag |

## Verification
The bench builds the block with the default 16-bit counter, so a reload of zero needs the full 65536-cycle wrap. That single long wait is inside the cycle budget and proves the zero case directly. Random reload values between 1 and 40 keep the periodic, clock-generation and slave-restart checks short, so many distinct periods can be tried. A reload of 1, which makes the timer fire every cycle, also falls within the random range.

// File: rtl/sck_rate_pkg.sv
package sck_rate_pkg;

    localparam int DEF_CNT_W = 16;

    localparam logic [1:0] ADDR_LO   = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_STAT = 2'd3;

    localparam int CTRL_W = 5;

    typedef struct packed {
        logic       cpol;    // bit 4: idle level of the generated clock
        logic       master;  // bit 3: generate clock when port is on
        logic       dual;    // bit 2: timer enable (port off) / live view (port on)
        logic [1:0] port;    // bits 1:0: zero means port switched off
    } ctrl_t;

    typedef enum logic [1:0] {
        ROLE_IDLE   = 2'd0,
        ROLE_TIMER  = 2'd1,
        ROLE_MASTER = 2'd2,
        ROLE_SLAVE  = 2'd3
    } role_e;

    function automatic role_e role_of(ctrl_t c);
        if (c.port == 2'b00) begin
            return c.dual ? ROLE_TIMER : ROLE_IDLE;
        end
        return c.master ? ROLE_MASTER : ROLE_SLAVE;
    endfunction

    function automatic logic live_view(ctrl_t c);
        return (c.port != 2'b00) && c.dual;
    endfunction

endpackage

// File: rtl/rate_counter.sv
module rate_counter #(
    parameter int CNT_W = sck_rate_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             tick
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    assign tick = run && (cnt == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!run || restart || tick) begin
            cnt <= reload;
        end else begin
            cnt <= cnt - ONE;
        end
    end
endmodule

// File: rtl/rate_sck.sv
module rate_sck
    import sck_rate_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  role_e role,
    input  logic  cpol,
    input  logic  tick,
    input  logic  sck_in,
    input  logic  clr_abort,
    output logic  sck_o,
    output logic  sck_edge,
    output logic  abort
);
    logic sck_q;
    logic expire;

    assign sck_edge = (role == ROLE_SLAVE) && (sck_in != sck_q);
    assign expire   = (role == ROLE_SLAVE) && tick && !sck_edge;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= 1'b0;
            sck_o <= 1'b0;
            abort <= 1'b0;
        end else begin
            sck_q <= sck_in;
            if (role == ROLE_MASTER) begin
                if (tick) begin
                    sck_o <= ~sck_o;
                end
            end else begin
                sck_o <= cpol;
            end
            if (expire) begin
                abort <= 1'b1;
            end else if (clr_abort) begin
                abort <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/rate_regs.sv
module rate_regs
    import sck_rate_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [HALF_W-1:0] wr_data,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              abort,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic [HALF_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rd_word,
    output logic              clr_abort
);
    logic [HALF_W-1:0] ctrl_raw;
    logic [HALF_W-1:0] shadow_lo;
    logic              shadow_ok;
    logic              live;
    logic [CNT_W-1:0]  src;

    assign ctrl      = ctrl_t'(ctrl_raw[CTRL_W-1:0]);
    assign live      = live_view(ctrl);
    assign src       = live ? cnt : reload;
    assign rd_word   = src;
    assign clr_abort = wr_en && (addr == ADDR_STAT) && wr_data[0];

    always_comb begin
        rd_data = '0;
        case (addr)
            ADDR_LO:   rd_data = (live && shadow_ok) ? shadow_lo : src[HALF_W-1:0];
            ADDR_HI:   rd_data = src[CNT_W-1:HALF_W];
            ADDR_CTRL: rd_data = ctrl_raw;
            default:   rd_data = {{(HALF_W-1){1'b0}}, abort};
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_raw  <= '0;
            reload    <= '0;
            shadow_lo <= '0;
            shadow_ok <= 1'b0;
        end else begin
            if (wr_en) begin
                case (addr)
                    ADDR_LO:   reload[HALF_W-1:0]     <= wr_data;
                    ADDR_HI:   reload[CNT_W-1:HALF_W] <= wr_data;
                    ADDR_CTRL: ctrl_raw               <= wr_data;
                    default:   ;
                endcase
            end
            if (rd_en && (addr == ADDR_HI) && live) begin
                shadow_lo <= src[HALF_W-1:0];
                shadow_ok <= 1'b1;
            end else if ((rd_en && (addr == ADDR_LO)) || !live) begin
                shadow_ok <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/sck_rate_gen.sv
module sck_rate_gen
    import sck_rate_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int HALF_W = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [HALF_W-1:0] wr_data,
    output logic [HALF_W-1:0] rd_data,
    output logic [CNT_W-1:0]  rd_word,
    input  logic              sck_in,
    output logic              sck_o,
    output logic              tmr_irq,
    output logic              abort
);
    ctrl_t            ctrl;
    role_e            role;
    logic [CNT_W-1:0] reload;
    logic [CNT_W-1:0] cnt;
    logic             tick;
    logic             sck_edge;
    logic             clr_abort;

    assign role    = role_of(ctrl);
    assign tmr_irq = tick && (role == ROLE_TIMER);

    rate_regs #(.CNT_W(CNT_W), .HALF_W(HALF_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .cnt       (cnt),
        .abort     (abort),
        .ctrl      (ctrl),
        .reload    (reload),
        .rd_data   (rd_data),
        .rd_word   (rd_word),
        .clr_abort (clr_abort)
    );

    rate_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .run     (role != ROLE_IDLE),
        .restart (sck_edge),
        .reload  (reload),
        .cnt     (cnt),
        .tick    (tick)
    );

    rate_sck u_sck (
        .clk       (clk),
        .rst       (rst),
        .role      (role),
        .cpol      (ctrl.cpol),
        .tick      (tick),
        .sck_in    (sck_in),
        .clr_abort (clr_abort),
        .sck_o     (sck_o),
        .sck_edge  (sck_edge),
        .abort     (abort)
    );
endmodule

// File: rtl/sck_rate_chk.sv
module sck_rate_chk
    import sck_rate_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic [1:0]       addr,
    input logic             sck_o,
    input logic             tmr_irq,
    input logic             abort,
    input ctrl_t            ctrl,
    input role_e            role,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] reload,
    input logic             tick,
    input logic             sck_edge,
    input logic             clr_abort
);
    logic ctrl_wr;
    logic expire;
    assign ctrl_wr = wr_en && (addr == ADDR_CTRL);
    assign expire  = (role == ROLE_SLAVE) && tick && !sck_edge;

    a_r4_irq_timer_only: assert property (@(posedge clk) disable iff (rst)
        tmr_irq |-> (ctrl.port == 2'b00) && ctrl.dual);

    a_r2_count_down: assert property (@(posedge clk) disable iff (rst)
        ((role != ROLE_IDLE) && !sck_edge && !tick) |=> cnt == $past(cnt) - CNT_W'(1));

    a_r5_sck_toggles: assert property (@(posedge clk) disable iff (rst)
        ((role == ROLE_MASTER) && tick && !ctrl_wr) |=> sck_o != $past(sck_o));

    a_r6_idle_level: assert property (@(posedge clk) disable iff (rst)
        ((role != ROLE_MASTER) && !ctrl_wr) |=> sck_o == ctrl.cpol);

    a_r7_edge_restart: assert property (@(posedge clk) disable iff (rst)
        sck_edge |=> cnt == $past(reload));

    a_r8_abort_set: assert property (@(posedge clk) disable iff (rst)
        expire |=> abort);

    a_r8_abort_sticky: assert property (@(posedge clk) disable iff (rst)
        (abort && !clr_abort) |=> abort);

    a_r8_abort_clear: assert property (@(posedge clk) disable iff (rst)
        (clr_abort && !expire) |=> !abort);
endmodule

bind sck_rate_gen sck_rate_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .sck_o     (sck_o),
    .tmr_irq   (tmr_irq),
    .abort     (abort),
    .ctrl      (ctrl),
    .role      (role),
    .cnt       (cnt),
    .reload    (reload),
    .tick      (tick),
    .sck_edge  (sck_edge),
    .clr_abort (clr_abort)
);

// File: tb/sck_rate_gen_tb.sv
module sck_rate_gen_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  wr_data = 8'd0;
    logic [7:0]  rd_data;
    logic [15:0] rd_word;
    logic        sck_in = 1'b0;
    logic        sck_o;
    logic        tmr_irq;
    logic        abort;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sck_rate_gen u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .rd_word(rd_word),
        .sck_in(sck_in), .sck_o(sck_o), .tmr_irq(tmr_irq), .abort(abort)
    );

    // control encodings: {cpol, master, dual, port[1:0]}
    function automatic logic [7:0] ctrl_val(bit cpol, bit master, bit dual, logic [1:0] port);
        return {3'b000, cpol, master, dual, port};
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(logic [1:0] a, logic [7:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_reload(int n);
        reg_write(2'd2, 8'h00);
        reg_write(2'd0, n[7:0]);
        reg_write(2'd1, n[15:8]);
    endtask

    task automatic wait_irq(output int cyc, input int limit);
        cyc = 0;
        while (!tmr_irq && cyc < limit) begin
            @(negedge clk);
            cyc++;
        end
    endtask

    task automatic sck_period(output int per);
        int t = 0;
        int first = -1;
        logic prev = sck_o;
        per = -1;
        while (t < 400) begin
            @(negedge clk);
            t++;
            if (sck_o && !prev) begin
                if (first < 0) first = t;
                else begin per = t - first; break; end
            end
            prev = sck_o;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, a, b, per, silent;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 sck_o", sck_o, 0);
        check("R1 tmr_irq", tmr_irq, 0);
        check("R1 abort", abort, 0);
        check("R1 rd_word", rd_word, 0);
        addr = 2'd2; #1;
        check("R1 ctrl", rd_data, 0);

        // R2 random timer periods
        for (int i = 0; i < 8; i++) begin
            n = (i == 0) ? 1 : 1 + int'($urandom % 40);
            set_reload(n);
            reg_write(2'd2, ctrl_val(0, 0, 1, 2'b00));
            wait_irq(a, 100);
            check("R2 first latency", a, n - 1);
            @(negedge clk);
            wait_irq(b, 100);
            check("R2 period", b + 1, n);
        end

        // R3 zero reload means 65536
        set_reload(0);
        reg_write(2'd2, ctrl_val(0, 0, 1, 2'b00));
        wait_irq(a, 70000);
        check("R3 zero reload latency", a, 65535);

        // R4 timer off, and silent in port-on roles
        set_reload(3);
        silent = 0;
        for (int k = 0; k < 40; k++) begin @(negedge clk); if (tmr_irq) silent++; end
        check("R4 timer off", silent, 0);
        reg_write(2'd2, ctrl_val(0, 1, 1, 2'b01));
        silent = 0;
        for (int k = 0; k < 40; k++) begin @(negedge clk); if (tmr_irq) silent++; end
        check("R4 no irq in master role", silent, 0);

        // R5 master clock period 2N
        for (int i = 0; i < 4; i++) begin
            n = 1 + int'($urandom % 40);
            set_reload(n);
            reg_write(2'd2, ctrl_val(0, 1, 0, 2'b01));
            sck_period(per);
            check("R5 sck period", per, 2 * n);
        end

        // R6 idle level
        reg_write(2'd2, ctrl_val(1, 0, 0, 2'b00));
        @(negedge clk);
        check("R6 idle high when off", sck_o, 1);
        reg_write(2'd2, ctrl_val(0, 0, 0, 2'b00));
        @(negedge clk);
        check("R6 idle low when off", sck_o, 0);

        // R7 / R8 slave inactivity
        set_reload(20);
        reg_write(2'd2, ctrl_val(1, 0, 0, 2'b01));
        @(negedge clk);
        check("R6 idle high in slave role", sck_o, 1);
        silent = 0;
        for (int k = 0; k < 12; k++) begin
            sck_in = ~sck_in;
            repeat (10) begin @(negedge clk); if (abort) silent++; end
        end
        check("R7 no abort while edges arrive", silent, 0);
        repeat (30) @(negedge clk);
        check("R8 abort after silence", abort, 1);
        reg_write(2'd2, ctrl_val(0, 0, 0, 2'b00));
        reg_write(2'd3, 8'h00);
        check("R8 write 0 keeps abort", abort, 1);
        reg_write(2'd3, 8'h01);
        check("R8 write 1 clears abort", abort, 0);

        // R9..R11 readback views
        set_reload(16'h1234);
        reg_write(2'd2, ctrl_val(0, 1, 1, 2'b01));
        repeat (5) @(negedge clk);
        check("R10 word tracks live count", rd_word, 16'h1234 - 5);
        rd_en = 1'b1; addr = 2'd1; #1;
        check("R9 live high byte", rd_data, 8'h12);
        @(negedge clk);
        rd_en = 1'b0;
        repeat (3) @(negedge clk);
        rd_en = 1'b1; addr = 2'd0; #1;
        check("R11 captured low byte", rd_data, 8'h2F);
        @(negedge clk);
        rd_en = 1'b0;
        reg_write(2'd2, ctrl_val(0, 1, 0, 2'b01));
        addr = 2'd0; #1;
        check("R9 reload view word", rd_word, 16'h1234);
        check("R9 reload view low", rd_data, 8'h34);
        reg_write(2'd2, ctrl_val(0, 0, 1, 2'b00));
        repeat (4) @(negedge clk);
        check("R9 port off reads reload", rd_word, 16'h1234);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule